// File: doc/BRIEF.md
# Dual-Mode SPI Serial Clock Prescaler

This block derives a serial clock for an SPI controller from the core clock. An 8-bit prescale code sets how many core clocks one serial-clock period lasts. A mode input selects how that code is read. In the legacy mode the code gives only even divide ratios from 4 to 30. In the extended mode the ratio is a 4-bit linear scaler multiplied by a power of two. The 3-bit exponent for that power is spread over non-adjacent bits of the code, because one bit in the middle belongs to a neighbouring control.

The block drives the serial clock with an idle level chosen by a polarity input. It also gives a one-core-clock pulse in every cycle where the serial clock has just changed, so that shift logic elsewhere can act on the edges without detecting them itself. An enable input stops the clock at its idle level and restarts the count from zero. A new prescale code or polarity is taken only when a full period ends, so a change never produces a shortened pulse. An illegal code holds the clock idle and raises an error flag.

Top module: `spi_sck_divider`

## Requirements
- R1: In extended mode (`ext_mode`=1) the divide ratio is S×2^E. S is `prescale[3:0]`. E is built from `prescale[4]` as bit 0, `prescale[6]` as bit 1 and `prescale[7]` as bit 2. `prescale[5]` has no effect. The largest ratio is 15×128 = 1920.
- R2: In extended mode a scaler S of 0 is illegal. `cfg_err` then reads 1, `sck` stays at the idle level and `sck_edge` stays 0 for as long as the code stays illegal.
- R3: In legacy mode (`ext_mode`=0) with `prescale[4]`=1, the ratio is twice `prescale[3:0]`. A nibble of 0 or 1 gives a ratio of 4, so ratios stay even and lie between 4 and 30. `prescale[7:5]` has no effect.
- R4: In legacy mode a code with `prescale[4]`=0 is illegal and is handled in the same way as in R2.
- R5: For a ratio r, each period has an active phase (`sck` opposite to `cpol`) that lasts ceil(r/2) core clocks, followed by an idle phase that lasts floor(r/2) core clocks, with at least 1. So odd ratios give an active phase one clock longer than the idle phase, and a ratio of 1 toggles `sck` on every core clock.
- R6: The idle level of `sck` equals `cpol`. While `enable` is 0, `sck` takes the current `cpol`.
- R7: `sck_edge` is 1 in exactly those cycles in which `sck` differs from its value in the previous cycle.
- R8: While `enable` is 0 the count is held at zero and `sck` is idle. When `enable` is first sampled high at clock edge 1, the first active edge of `sck` appears at clock edge floor(r/2) (at least 1).
- R9: A prescale code or `cpol` that changes while the block runs takes effect only when an active phase ends. The current period keeps its old phase lengths.
- R10: During reset, `sck`, `sck_edge` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the divider; low holds it at idle with the count at zero |
| ext_mode | input | 1 | 1 selects the extended encoding, 0 the legacy encoding |
| cpol | input | 1 | Idle level of the serial clock |
| prescale | input | 8 | Prescale code |
| sck | output | 1 | Serial clock |
| sck_edge | output | 1 | One-cycle pulse in each cycle in which `sck` has just changed |
| cfg_err | output | 1 | The code in use is illegal |

## Verification
The bench uses the default parameters: a 4-bit scaler, a 3-bit exponent and legacy limits of 4 and 30. At these sizes even the longest ratio of 1920 costs only a few thousand cycles. That makes it practical to sweep all 128 scaler/exponent pairs, with the unused bit 5 toggled along the way, and all 32 legacy low-field codes with varied upper bits and both polarities. For each legal code the bench times the first edge, the active phase and the idle phase against arithmetic expectations. For each illegal code it checks that the clock stays idle. Directed cases cover a restart in the middle of a phase and a code change in the middle of a period.

// File: rtl/sckdiv_pkg.sv
// Package: shared field layout, derived widths and the phase-length record
// passed from the decoder to the phase generator.
// Assumes an 8-bit prescale code whose exponent bits sit at 4, 6 and 7.
package sckdiv_pkg;

    localparam int PS_W        = 8;                         // prescale code width
    localparam int SCALER_W    = 4;                         // linear scaler width
    localparam int EXP_W       = 3;                         // exponent width
    localparam int EXP_LSB_POS = 4;                         // exponent bit 0 position
    localparam int EXP_HI_POS  = 6;                         // exponent bit 1 position, bit 2 follows
    localparam int LEG_EN_POS  = 4;                         // legacy "valid" marker bit
    localparam int RATIO_W     = SCALER_W + (1 << EXP_W) - 1; // fits 15 << 7

    typedef enum logic {
        MODE_LEGACY = 1'b0,
        MODE_EXT    = 1'b1
    } sckdiv_mode_e;

    typedef struct packed {
        logic [RATIO_W-1:0] lead;   // active phase length in core clocks
        logic [RATIO_W-1:0] trail;  // idle phase length in core clocks
        logic               err;    // code is illegal
    } sckdiv_cfg_t;

endpackage

// File: rtl/sckdiv_decode.sv
// Module: sckdiv_decode
// Turns a prescale code and mode into active/idle phase lengths.
// Extended: ratio = scaler << exponent, with the exponent gathered from bits
// that are not adjacent. Legacy: ratio = 2 * low nibble, clamped.
// Assumes: purely combinational; clk/rst_n are used only by the assertions.
module sckdiv_decode
    import sckdiv_pkg::*;
#(
    parameter int LEG_MIN_RATIO = 4,
    parameter int LEG_MAX_RATIO = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_mode,
    input  logic [PS_W-1:0]  prescale,
    output sckdiv_cfg_t      cfg
);

    logic [SCALER_W-1:0] scaler;
    logic [EXP_W-1:0]    exp_v;
    logic [RATIO_W-1:0]  ext_ratio;
    logic [RATIO_W-1:0]  leg_raw;
    logic [RATIO_W-1:0]  leg_ratio;
    logic [RATIO_W-1:0]  ratio;
    logic [RATIO_W:0]    ratio_p1;
    logic [RATIO_W-1:0]  half_dn;
    logic                err;
    sckdiv_mode_e        mode;
    logic                unused_bits;

    assign mode        = sckdiv_mode_e'(ext_mode);
    assign scaler      = prescale[SCALER_W-1:0];
    assign unused_bits = ^prescale[5];

    // Gather exponent bits from their scattered positions
    for (genvar g = 0; g < EXP_W; g++) begin : g_exp
        localparam int POS = (g == 0) ? EXP_LSB_POS : EXP_HI_POS + g - 1;
        assign exp_v[g] = prescale[POS];
    end

    // Extended ratio: linear scaler times power of two
    assign ext_ratio = RATIO_W'(scaler) << exp_v;

    // Legacy ratio: twice the low nibble, clamped to the legal range
    always_comb begin
        leg_raw = RATIO_W'({scaler, 1'b0});
        if (leg_raw < RATIO_W'(LEG_MIN_RATIO))
            leg_ratio = RATIO_W'(LEG_MIN_RATIO);
        else if (leg_raw > RATIO_W'(LEG_MAX_RATIO))
            leg_ratio = RATIO_W'(LEG_MAX_RATIO);
        else
            leg_ratio = leg_raw;
    end

    // Mode selection and legality
    always_comb begin
        if (mode == MODE_EXT) begin
            ratio = ext_ratio;
            err   = (scaler == '0);
        end else begin
            ratio = leg_ratio;
            err   = !prescale[LEG_EN_POS];
        end
    end

    // Split the ratio: active phase rounds up, idle phase rounds down (min 1)
    always_comb begin
        ratio_p1 = {1'b0, ratio} + 1'b1;
        half_dn  = {1'b0, ratio[RATIO_W-1:1]};
        cfg.lead  = ratio_p1[RATIO_W:1];
        cfg.trail = (half_dn == '0) ? RATIO_W'(1) : half_dn;
        cfg.err   = err;
    end

    // R3: legacy legal codes give even ratios inside the limits
    assert_legacy_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && !cfg.err) |->
            (ratio >= RATIO_W'(LEG_MIN_RATIO) && ratio <= RATIO_W'(LEG_MAX_RATIO) && !ratio[0]));

    // R5: phases differ by at most one clock, active never shorter
    assert_phase_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.err |-> (cfg.trail >= RATIO_W'(1) && cfg.lead >= cfg.trail &&
                      (cfg.lead - cfg.trail) <= RATIO_W'(1)));

endmodule

// File: rtl/sckdiv_phase_gen.sv
// Module: sckdiv_phase_gen
// Counts core clocks through an idle phase then an active phase, drives the
// serial clock and an edge pulse. A new code/polarity is loaded only when an
// active phase ends, while disabled, or while the loaded code is illegal.
// Assumes cfg.lead and cfg.trail are at least 1.
module sckdiv_phase_gen
    import sckdiv_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        cpol,
    input  sckdiv_cfg_t cfg,
    output logic        sck,
    output logic        sck_edge,
    output logic        cfg_err
);

    logic [RATIO_W-1:0] cnt_q, cnt_d;
    logic [RATIO_W-1:0] cur_lead_q, cur_trail_q;
    logic               cur_err_q, cur_cpol_q;
    logic               active_q, active_d;
    logic               sck_q, sck_d;
    logic               edge_q;
    logic               load;

    // Next-state: restart, idle phase count, active phase count
    always_comb begin
        cnt_d    = cnt_q;
        active_d = active_q;
        sck_d    = sck_q;
        load     = 1'b0;
        if (!enable || cur_err_q) begin
            load     = 1'b1;
            active_d = 1'b0;
            cnt_d    = '0;
            sck_d    = cpol;
        end else if (!active_q) begin
            if (cnt_q == cur_trail_q - 1'b1) begin
                active_d = 1'b1;
                cnt_d    = '0;
                sck_d    = ~cur_cpol_q;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end else begin
            if (cnt_q == cur_lead_q - 1'b1) begin
                active_d = 1'b0;
                cnt_d    = '0;
                sck_d    = cpol;
                load     = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    // State registers and period-boundary configuration load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            active_q    <= 1'b0;
            sck_q       <= 1'b0;
            edge_q      <= 1'b0;
            cur_lead_q  <= RATIO_W'(2);
            cur_trail_q <= RATIO_W'(2);
            cur_err_q   <= 1'b0;
            cur_cpol_q  <= 1'b0;
        end else begin
            cnt_q    <= cnt_d;
            active_q <= active_d;
            sck_q    <= sck_d;
            edge_q   <= (sck_d != sck_q);
            if (load) begin
                cur_lead_q  <= cfg.lead;
                cur_trail_q <= cfg.trail;
                cur_err_q   <= cfg.err;
                cur_cpol_q  <= cpol;
            end
        end
    end

    assign sck      = sck_q;
    assign sck_edge = edge_q;
    assign cfg_err  = cur_err_q;

    // R7: edge pulse marks exactly the cycles where sck just changed
    assert_edge_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        edge_q == (sck_q != $past(sck_q)));

    // R2: an illegal loaded code keeps the clock idle
    assert_err_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cur_err_q |-> (sck_q == cur_cpol_q && !active_q));

    // R5: counter stays inside the current phase length
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        active_q ? (cnt_q < cur_lead_q) : (cnt_q < cur_trail_q));

    // R8: disabled means count zero, idle level
    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(enable)) |->
            (!active_q && cnt_q == '0 && sck_q == $past(cpol)));

    // R9: configuration is frozen inside an active phase
    assert_no_midphase_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && $past(active_q)) |->
            ($stable(cur_lead_q) && $stable(cur_trail_q) && $stable(cur_cpol_q)));

endmodule

// File: rtl/spi_sck_divider.sv
// Module: spi_sck_divider (top)
// Serial clock prescaler with a legacy even-ratio encoding and an extended
// scaler x power-of-two encoding. Decoder feeds the phase generator.
// Assumes all inputs are synchronous to clk.
module spi_sck_divider
    import sckdiv_pkg::*;
#(
    parameter int LEG_MIN_RATIO = 4,
    parameter int LEG_MAX_RATIO = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            ext_mode,
    input  logic            cpol,
    input  logic [PS_W-1:0] prescale,
    output logic            sck,
    output logic            sck_edge,
    output logic            cfg_err
);

    sckdiv_cfg_t dec_cfg;

    sckdiv_decode #(
        .LEG_MIN_RATIO (LEG_MIN_RATIO),
        .LEG_MAX_RATIO (LEG_MAX_RATIO)
    ) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_mode (ext_mode),
        .prescale (prescale),
        .cfg      (dec_cfg)
    );

    sckdiv_phase_gen u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .cpol     (cpol),
        .cfg      (dec_cfg),
        .sck      (sck),
        .sck_edge (sck_edge),
        .cfg_err  (cfg_err)
    );

    // R10: outputs low while in reset
    assert_reset_quiet_R10: assert property (@(posedge clk)
        $past(!rst_n) |-> (!sck && !sck_edge && !cfg_err));

endmodule

// File: tb/tb_spi_sck_divider.sv
module tb_spi_sck_divider;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       ext_mode = 1'b0;
    logic       cpol = 1'b0;
    logic [7:0] prescale = 8'h00;
    logic       sck, sck_edge, cfg_err;

    int tests = 0;
    int fails = 0;

    spi_sck_divider dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ext_mode(ext_mode),
        .cpol(cpol), .prescale(prescale), .sck(sck), .sck_edge(sck_edge),
        .cfg_err(cfg_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Expected ratio per the requirements; returns -1 when illegal
    function automatic int exp_ratio(input bit m, input logic [7:0] ps);
        int s, e, n;
        if (m) begin
            s = int'(ps[3:0]);
            e = int'({ps[7], ps[6], ps[4]});
            if (s == 0) return -1;
            return s * (1 << e);
        end
        if (!ps[4]) return -1;
        n = int'(ps[3:0]);
        if (n < 2) return 4;
        return 2 * n;
    endfunction

    // Load a code while disabled, then time the first three sck changes
    task automatic run_case(input bit m, input logic [7:0] ps, input bit cp);
        int r, lead, trail, n, bad, lvl0;
        int t[3];
        string rq, eq;
        r     = exp_ratio(m, ps);
        rq    = m ? "R1" : "R3";
        eq    = m ? "R2" : "R4";
        enable = 1'b0; ext_mode = m; prescale = ps; cpol = cp;
        tick(); tick(); tick();
        check(sck == cp, "R6", "idle level while disabled", sck, cp);
        check(cfg_err == (r < 0), eq, "error flag", cfg_err, r < 0);
        enable = 1'b1;
        if (r < 0) begin
            bad = 0;
            repeat (40) begin
                tick();
                if (sck != cp || sck_edge || !cfg_err) bad++;
            end
            check(bad == 0, eq, "illegal code held idle (bad cycles)", bad, 0);
        end else begin
            lead  = (r + 1) / 2;
            trail = (r / 2 < 1) ? 1 : r / 2;
            n = 0; bad = 0; lvl0 = -1;
            t[0] = 0; t[1] = 0; t[2] = 0;
            for (int cyc = 1; cyc <= 2 * r + 8 && n < 3; cyc++) begin
                logic prev;
                prev = sck;
                tick();
                if (sck != prev) begin
                    t[n] = cyc;
                    if (n == 0) lvl0 = int'(sck);
                    n++;
                    if (!sck_edge) bad++;
                end else if (sck_edge) bad++;
            end
            check(n == 3, rq, "sck edges seen", n, 3);
            check(t[0] == trail, "R8", "first edge clock", t[0], trail);
            check(lvl0 == int'(!cp), "R6", "active level", lvl0, int'(!cp));
            check(t[1] - t[0] == lead, rq, "active phase (R5)", t[1] - t[0], lead);
            check(t[2] - t[1] == trail, rq, "idle phase (R5)", t[2] - t[1], trail);
            check(bad == 0, "R7", "edge pulse mismatches", bad, 0);
            check(cfg_err == 1'b0, eq, "no error on legal code", cfg_err, 0);
        end
        enable = 1'b0;
        tick();
    endtask

    // Wait for the next sck change; returns cycles waited
    task automatic wait_change(output int cycles);
        logic prev;
        cycles = 0;
        prev = sck;
        do begin
            tick();
            cycles++;
        end while (sck == prev && cycles < 5000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int d;
        // R10: reset state, with an illegal code on the inputs
        tick(); tick();
        check(sck == 1'b0 && sck_edge == 1'b0 && cfg_err == 1'b0, "R10",
              "outputs in reset", {sck, sck_edge, cfg_err}, 0);
        rst_n = 1'b1;
        tick();

        // R1/R2: all scaler/exponent pairs, bit 5 toggled, both polarities
        for (int s = 0; s < 16; s++) begin
            for (int e = 0; e < 8; e++) begin
                logic [7:0] ps;
                ps = {e[2], e[1], 1'(s + e), e[0], s[3:0]};
                run_case(1'b1, ps, e[0]);
            end
        end

        // R3/R4: every legacy low field, upper bits varied
        for (int i = 0; i < 32; i++) begin
            logic [7:0] ps;
            logic [2:0] hi;
            hi = 3'(i * 5);
            ps = {hi, i[4:0]};
            run_case(1'b0, ps, i[0]);
        end

        // R8: restart in the middle of an active phase (ratio 10)
        enable = 1'b0; ext_mode = 1'b1; cpol = 1'b1; prescale = 8'h0A;
        tick(); tick();
        enable = 1'b1;
        wait_change(d);
        check(d == 5, "R8", "first edge before restart", d, 5);
        tick(); tick();
        enable = 1'b0;
        tick();
        check(sck == 1'b1 && sck_edge == 1'b1, "R8", "forced idle on disable",
              {sck, sck_edge}, 2'b11);
        tick();
        check(sck_edge == 1'b0, "R7", "single pulse", sck_edge, 0);
        enable = 1'b1;
        wait_change(d);
        check(d == 5, "R8", "first edge after restart", d, 5);

        // R9: code change inside an active phase waits for the period end
        enable = 1'b0; cpol = 1'b0; prescale = 8'h08;
        tick(); tick();
        enable = 1'b1;
        wait_change(d);
        check(d == 4, "R9", "first edge old code", d, 4);
        tick();
        prescale = 8'h02;
        cpol = 1'b0;
        wait_change(d);
        check(d == 3, "R9", "remaining old active phase", d, 3);
        wait_change(d);
        check(d == 1, "R9", "new idle phase", d, 1);
        wait_change(d);
        check(d == 1, "R9", "new active phase", d, 1);

        // R2: illegal code loaded at a period end halts the clock
        prescale = 8'h00;
        wait_change(d);
        wait_change(d);
        repeat (3) tick();
        check(cfg_err == 1'b1 && sck == 1'b0, "R2", "halt on illegal code",
              {cfg_err, sck}, 2'b10);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule